// File: doc/BRIEF.md
# Sequence-Unlocked Drive Timing Configuration Bank

This block sits behind the eight command-block I/O offsets of a legacy disk task-file port. Normally every read and write at those offsets reaches an ordinary task-file register stub. The drive-timing configuration registers have no address of their own. Software reaches them by making a fixed pattern of ordinary accesses: two 16-bit reads at offset 1, then a byte write of 0x03 to offset 2. That pattern opens a configuration window. While the window is open, five of the offsets reach the configuration registers instead of the task file. A byte write of 0x83 to offset 2 closes the window again.

The configuration registers are a read-timing byte and a write-timing byte for each drive, a control byte and a miscellaneous byte. The miscellaneous byte selects the drive and holds the shared address-setup field. The latched timings and the override flag are driven out as ports for the bus-cycle logic. A separate probe returns a clock-speed strap input when software asks for it with a write and then a read at offset 5.

The unlock sequencer has four states:
- `ST_LOCKED` is the idle state.
- `ST_RD1` means one key read has been seen.
- `ST_RD2` means two consecutive key reads have been seen.
- `ST_OPEN` means the window is open.

Its transitions are:
- key read: `ST_LOCKED`→`ST_RD1` and `ST_RD1`→`ST_RD2`. A further key read holds `ST_RD2`.
- open key: `ST_RD2`→`ST_OPEN`.
- close key: `ST_OPEN`→`ST_LOCKED`.
- break: from `ST_RD1` or `ST_RD2` to `ST_LOCKED`, on any other access.

Top module: `cfg_trapdoor_bank`

## Requirements
- R1: After reset the window is closed and the override flag is low. Both timing bytes of every drive are 0x6B. The miscellaneous byte is 0x30, so the address-setup field reads 3 and drive 0 is selected. The control byte and every task-file register are zero.
- R2: The window opens on the clock edge that accepts the third access of this pattern: a 16-bit read at offset 1, then another 16-bit read at offset 1, then a byte write of 0x03 to offset 2. No other access may come between them. `cfg_open` rises on that edge.
- R3: Certain accesses return the sequencer to idle before the window opens: a read or write at another offset, a byte-size read at offset 1, a write at offset 1, or a write of any value other than 0x03 to offset 2. Software must then begin the pattern again. A third 16-bit read at offset 1 keeps the two-read progress.
- R4: While the window is closed, every write at every offset goes to the task-file stub. A byte write changes only the low byte; a word write changes all 16 bits. No timing byte, control byte or miscellaneous byte changes, and reads return the task-file content.
- R5: While the window is open, a write at offset 0 loads the read-timing byte, and a write at offset 1 loads the write-timing byte. The low data byte is used, and only the drive selected by the miscellaneous register is written.
- R6: While the window is open, a write at offset 6 loads the miscellaneous byte. Bit 0 of that byte selects the drive and bits 5:4 drive the `addr_setup` output.
- R7: While the window is open, a write at offset 3 loads the control byte. `tmg_override` is high exactly while the control byte equals 0x85.
- R8: While the window is open, a byte write of 0x83 to offset 2 closes it. Any other write to offset 2 is dropped and leaves the window open.
- R9: A byte write of 0xFF to offset 5 arms a strap probe. If the very next access is a 16-bit read at offset 5, it returns `strap_in` in bit 0 and zeros above it. Any other access disarms the probe. While the window is closed, the arming write also reaches the task file.
- R10: While the window is open, reads return a configuration byte in bits 7:0 with zeros above it. Offset 0 gives the selected drive's read timing and offset 1 its write timing. Offset 3 gives the control byte, offset 6 the miscellaneous byte, and offset 5 the strap. Offsets 2, 4 and 7 still read the task file, and offsets 4 and 7 still take writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Command-block register offset |
| io_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for the current offset (combinational) |
| strap_in | input | 1 | Clock-speed strap level |
| rd_tmg | output | 16 | Read-timing bytes, drive 1 in bits 15:8 and drive 0 in bits 7:0 |
| wr_tmg | output | 16 | Write-timing bytes, with the same layout as `rd_tmg` |
| addr_setup | output | 2 | Shared address-setup field |
| dev_sel | output | 1 | Drive selected for timing writes |
| tmg_override | output | 1 | Programmed timings take precedence over the strap |
| cfg_open | output | 1 | Configuration window is open |

## Verification
Suppose the sequencer state is wrong. If it opens too early or stays open too long, the next write at offset 0 or 1 changes `rd_tmg` or `wr_tmg` on the following edge. If it fails to open, a later read at offset 6 returns task-file data where the bench expects the miscellaneous byte. If the drive select is wrong, the wrong byte lane of the timing outputs moves one cycle after the write. A stale probe flag shows on the very next 16-bit read at offset 5. The random phase mixes broken and complete unlock patterns and compares every port after every access, so a divergence shows up within one access.

// File: rtl/cfg_trapdoor_pkg.sv
package cfg_trapdoor_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_RD1,
        ST_RD2,
        ST_OPEN
    } seq_state_t;

    localparam int          ADDR_W     = 3;
    localparam logic [2:0]  OFS_RDTMG  = 3'd0;
    localparam logic [2:0]  OFS_WRTMG  = 3'd1;
    localparam logic [2:0]  OFS_KEY    = 3'd2;
    localparam logic [2:0]  OFS_CTRL   = 3'd3;
    localparam logic [2:0]  OFS_STRAP  = 3'd5;
    localparam logic [2:0]  OFS_MISC   = 3'd6;
    localparam logic [7:0]  KEY_OPEN   = 8'h03;
    localparam logic [7:0]  KEY_CLOSE  = 8'h83;
    localparam logic [7:0]  CTRL_OVR   = 8'h85;
    localparam logic [7:0]  STRAP_ARM  = 8'hFF;

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
    import cfg_trapdoor_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic       word,
    input  logic [2:0] addr,
    input  logic [7:0] wbyte,
    output logic       open,
    output logic       probe_armed
);

    seq_state_t st, st_nx;
    logic any_acc, key_rd, open_wr, close_wr, arm_wr;

    assign any_acc  = rd_stb | wr_stb;
    assign key_rd   = rd_stb && word && (addr == OFS_WRTMG);
    assign open_wr  = wr_stb && !word && (addr == OFS_KEY) && (wbyte == KEY_OPEN);
    assign close_wr = wr_stb && !word && (addr == OFS_KEY) && (wbyte == KEY_CLOSE);
    assign arm_wr   = wr_stb && !word && (addr == OFS_STRAP) && (wbyte == STRAP_ARM);

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOCKED: if (key_rd) st_nx = ST_RD1;
            ST_RD1: begin
                if (key_rd)       st_nx = ST_RD2;
                else if (any_acc) st_nx = ST_LOCKED;
            end
            ST_RD2: begin
                if (open_wr)      st_nx = ST_OPEN;
                else if (key_rd)  st_nx = ST_RD2;
                else if (any_acc) st_nx = ST_LOCKED;
            end
            ST_OPEN: if (close_wr) st_nx = ST_LOCKED;
            default: st_nx = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_LOCKED;
        else        st <= st_nx;
    end

    always_comb begin
        open = (st == ST_OPEN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       probe_armed <= 1'b0;
        else if (any_acc) probe_armed <= arm_wr;
    end

    // R2: the window only opens on the open key
    a_r2_open_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(wr_stb && !word && addr == OFS_KEY && wbyte == KEY_OPEN));

    // R8: the window only closes on the close key
    a_r8_close_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open) |-> $past(wr_stb && !word && addr == OFS_KEY && wbyte == KEY_CLOSE));

    // R3: the open key only opens after two key reads
    a_r3_open_needs_reads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(st == ST_RD2));

    // R9: the probe arms only on the arming write
    a_r9_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_armed) |-> $past(wr_stb && addr == OFS_STRAP && wbyte == STRAP_ARM));

endmodule

// File: rtl/cfg_timing_regs.sv
module cfg_timing_regs
    import cfg_trapdoor_pkg::*;
#(
    parameter int         SEL_W    = 1,
    parameter logic [7:0] TMG_RST  = 8'h6B,
    parameter logic [7:0] MISC_RST = 8'h30,
    localparam int        DEVS     = 1 << SEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open,
    input  logic            wr_stb,
    input  logic [2:0]      addr,
    input  logic [7:0]      wbyte,
    output logic [DEVS*8-1:0] rd_tmg,
    output logic [DEVS*8-1:0] wr_tmg,
    output logic [7:0]      ctrl,
    output logic [7:0]      misc
);

    logic [SEL_W-1:0] sel;
    logic             cfg_wr;

    assign sel    = misc[SEL_W-1:0];
    assign cfg_wr = open && wr_stb;

    for (genvar d = 0; d < DEVS; d++) begin : g_dev
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_tmg[d*8 +: 8] <= TMG_RST;
                wr_tmg[d*8 +: 8] <= TMG_RST;
            end else if (cfg_wr && sel == SEL_W'(d)) begin
                if (addr == OFS_RDTMG) rd_tmg[d*8 +: 8] <= wbyte;
                if (addr == OFS_WRTMG) wr_tmg[d*8 +: 8] <= wbyte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= 8'h00;
            misc <= MISC_RST;
        end else if (cfg_wr) begin
            if (addr == OFS_CTRL) ctrl <= wbyte;
            if (addr == OFS_MISC) misc <= wbyte;
        end
    end

    // R4: nothing in the bank moves while the window is closed
    a_r4_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> ($stable(rd_tmg) && $stable(wr_tmg) && $stable(ctrl) && $stable(misc)));

    // R5: one write touches at most one drive's timing byte
    a_r5_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones({rd_tmg ^ $past(rd_tmg), wr_tmg ^ $past(wr_tmg)}) <= 8);

endmodule

// File: rtl/tf_stub.sv
module tf_stub #(
    parameter int  REGS   = 8,
    parameter int  W      = 16,
    localparam int AW     = $clog2(REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          word,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [REGS];

    for (genvar i = 0; i < REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en && addr == AW'(i)) begin
                if (word) mem[i] <= wdata;
                else      mem[i][7:0] <= wdata[7:0];
            end
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/cfg_trapdoor_bank.sv
module cfg_trapdoor_bank
    import cfg_trapdoor_pkg::*;
#(
    parameter int         SEL_W    = 1,
    parameter logic [7:0] TMG_RST  = 8'h6B,
    parameter logic [7:0] MISC_RST = 8'h30,
    localparam int        DEVS     = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        io_addr,
    input  logic              io_word,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic              strap_in,
    output logic [DEVS*8-1:0] rd_tmg,
    output logic [DEVS*8-1:0] wr_tmg,
    output logic [1:0]        addr_setup,
    output logic [SEL_W-1:0]  dev_sel,
    output logic              tmg_override,
    output logic              cfg_open
);

    localparam int TF_REGS = 1 << ADDR_W;

    logic        probe_armed, cfg_ofs, tf_wr;
    logic [7:0]  ctrl, misc, cfg_byte;
    logic [15:0] tf_rdata;

    cfg_unlock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_stb(io_rd), .wr_stb(io_wr),
        .word(io_word), .addr(io_addr), .wbyte(io_wdata[7:0]),
        .open(cfg_open), .probe_armed(probe_armed)
    );

    cfg_timing_regs #(.SEL_W(SEL_W), .TMG_RST(TMG_RST), .MISC_RST(MISC_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .open(cfg_open), .wr_stb(io_wr),
        .addr(io_addr), .wbyte(io_wdata[7:0]),
        .rd_tmg(rd_tmg), .wr_tmg(wr_tmg), .ctrl(ctrl), .misc(misc)
    );

    always_comb begin
        cfg_ofs = (io_addr == OFS_RDTMG) || (io_addr == OFS_WRTMG) ||
                  (io_addr == OFS_CTRL)  || (io_addr == OFS_STRAP) ||
                  (io_addr == OFS_MISC);
        tf_wr   = io_wr && (!cfg_open || (!cfg_ofs && io_addr != OFS_KEY));
    end

    tf_stub #(.REGS(TF_REGS), .W(16)) u_tf (
        .clk(clk), .rst_n(rst_n), .wr_en(tf_wr), .word(io_word),
        .addr(io_addr), .wdata(io_wdata), .rdata(tf_rdata)
    );

    always_comb begin
        cfg_byte = 8'h00;
        case (io_addr)
            OFS_RDTMG: cfg_byte = rd_tmg[dev_sel*8 +: 8];
            OFS_WRTMG: cfg_byte = wr_tmg[dev_sel*8 +: 8];
            OFS_CTRL:  cfg_byte = ctrl;
            OFS_STRAP: cfg_byte = {7'd0, strap_in};
            OFS_MISC:  cfg_byte = misc;
            default:   cfg_byte = 8'h00;
        endcase
        if (cfg_open && cfg_ofs)
            io_rdata = {8'h00, cfg_byte};
        else if (probe_armed && io_word && io_addr == OFS_STRAP)
            io_rdata = {15'd0, strap_in};
        else
            io_rdata = tf_rdata;
    end

    assign addr_setup   = misc[5:4];
    assign dev_sel      = misc[SEL_W-1:0];
    assign tmg_override = (ctrl == CTRL_OVR);

    // R7: override rises only after a control write inside the window
    a_r7_override_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmg_override) |-> $past(cfg_open && io_wr && io_addr == OFS_CTRL));

    // R6: address-setup field is held while the window is closed
    a_r6_setup_held: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(addr_setup));

    // strobes are mutually exclusive
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

endmodule

// File: tb/sim_cfg_trapdoor_bank.sv
module sim_cfg_trapdoor_bank;

    logic        clk = 0, rst_n = 0;
    logic [2:0]  io_addr = 0;
    logic        io_word = 0, io_rd = 0, io_wr = 0, strap_in = 0;
    logic [15:0] io_wdata = 0, io_rdata, rd_tmg, wr_tmg;
    logic [1:0]  addr_setup;
    logic        dev_sel, tmg_override, cfg_open;

    cfg_trapdoor_bank u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_word(io_word),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .strap_in(strap_in), .rd_tmg(rd_tmg), .wr_tmg(wr_tmg),
        .addr_setup(addr_setup), .dev_sel(dev_sel),
        .tmg_override(tmg_override), .cfg_open(cfg_open)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model (0 locked, 1 one read, 2 two reads, 3 open)
    int         m_st;
    bit         m_arm;
    logic [7:0] m_rd [2];
    logic [7:0] m_wr [2];
    logic [7:0] m_ctrl, m_misc;
    logic [15:0] m_tf [8];

    task automatic model_reset();
        m_st = 0; m_arm = 0; m_ctrl = 8'h00; m_misc = 8'h30;
        for (int i = 0; i < 2; i++) begin m_rd[i] = 8'h6B; m_wr[i] = 8'h6B; end
        for (int i = 0; i < 8; i++) m_tf[i] = 16'h0;
    endtask

    function automatic bit is_cfg(int a);
        return (a == 0 || a == 1 || a == 3 || a == 5 || a == 6);
    endfunction

    function automatic logic [15:0] exp_rdata(int a, bit word);
        logic [7:0] b;
        if (m_st == 3 && is_cfg(a)) begin
            case (a)
                0: b = m_rd[m_misc[0]];
                1: b = m_wr[m_misc[0]];
                3: b = m_ctrl;
                5: b = {7'd0, strap_in};
                default: b = m_misc;
            endcase
            return {8'h00, b};
        end
        if (m_arm && word && a == 5) return {15'd0, strap_in};
        return m_tf[a];
    endfunction

    function automatic logic [37:0] exp_out();
        return {m_st == 3, m_ctrl == 8'h85, m_misc[5:4], m_misc[0],
                m_rd[1], m_rd[0], m_wr[1], m_wr[0]};
    endfunction

    task automatic model_update(bit w, bit word, int a, logic [15:0] d);
        bit key_rd, open_wr, close_wr;
        int ns;
        key_rd   = !w && word && a == 1;
        open_wr  = w && !word && a == 2 && d[7:0] == 8'h03;
        close_wr = w && !word && a == 2 && d[7:0] == 8'h83;
        ns = m_st;
        case (m_st)
            0: if (key_rd) ns = 1;
            1: ns = key_rd ? 2 : 0;
            2: ns = open_wr ? 3 : (key_rd ? 2 : 0);
            default: if (close_wr) ns = 0;
        endcase
        if (w && m_st == 3) begin
            case (a)
                0: m_rd[m_misc[0]] = d[7:0];
                1: m_wr[m_misc[0]] = d[7:0];
                3: m_ctrl = d[7:0];
                6: m_misc = d[7:0];
                default: ;
            endcase
        end
        if (w && (m_st != 3 || (!is_cfg(a) && a != 2))) begin
            if (word) m_tf[a] = d;
            else      m_tf[a][7:0] = d[7:0];
        end
        m_arm = w && !word && a == 5 && d[7:0] == 8'hFF;
        m_st = ns;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(bit w, bit word, int a, logic [15:0] d, string tag);
        @(negedge clk);
        io_wr = w; io_rd = !w; io_word = word; io_addr = 3'(a); io_wdata = d;
        #1;
        if (!w) check(tag, 64'(io_rdata), 64'(exp_rdata(a, word)));
        @(posedge clk);
        model_update(w, word, a, d);
        @(negedge clk);
        io_wr = 0; io_rd = 0;
        #1;
        check(tag, 64'({cfg_open, tmg_override, addr_setup, dev_sel, rd_tmg, wr_tmg}),
              64'(exp_out()));
    endtask

    task automatic unlock(string tag);
        acc(0, 1, 1, 0, tag);
        acc(0, 1, 1, 0, tag);
        acc(1, 0, 2, 16'h0003, tag);
    endtask

    initial begin
        #600000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        // R1 reset state
        check("R1", 64'({cfg_open, tmg_override, addr_setup, dev_sel, rd_tmg, wr_tmg}),
              64'({1'b0, 1'b0, 2'd3, 1'b0, 16'h6B6B, 16'h6B6B}));
        // R3 broken sequences
        acc(0, 1, 1, 0, "R3"); acc(0, 1, 1, 0, "R3"); acc(0, 1, 0, 0, "R3");
        acc(1, 0, 2, 16'h0003, "R3");
        acc(0, 0, 1, 0, "R3"); acc(0, 0, 1, 0, "R3"); acc(1, 0, 2, 16'h0003, "R3");
        acc(0, 1, 1, 0, "R3"); acc(0, 1, 1, 0, "R3"); acc(1, 0, 2, 16'h0004, "R3");
        acc(1, 0, 2, 16'h0003, "R3");
        // R4 locked writes land in the task file only
        acc(1, 0, 0, 16'h5511, "R4"); acc(1, 1, 6, 16'hBEEF, "R4");
        acc(0, 1, 0, 0, "R4"); acc(0, 1, 6, 0, "R4");
        // R2 correct unlock (three key reads also accepted)
        acc(0, 1, 1, 0, "R2");
        unlock("R2");
        // R6 / R5 drive select and timing loads
        acc(1, 0, 6, 16'h0001, "R6");
        acc(1, 0, 0, 16'h0058, "R5"); acc(1, 0, 1, 16'h0044, "R5");
        acc(1, 0, 6, 16'h0020, "R6");
        acc(1, 0, 0, 16'h0042, "R5"); acc(1, 1, 1, 16'hAA32, "R5");
        // R10 open reads and pass-through offsets
        acc(0, 1, 0, 0, "R10"); acc(0, 0, 1, 0, "R10"); acc(0, 1, 6, 0, "R10");
        acc(1, 1, 4, 16'h1234, "R10"); acc(0, 1, 4, 0, "R10"); acc(0, 1, 2, 0, "R10");
        // R7 control/override
        acc(1, 0, 3, 16'h0085, "R7"); acc(0, 1, 3, 0, "R7");
        acc(1, 0, 3, 16'h0084, "R7"); acc(1, 0, 3, 16'h0085, "R7");
        // R8 relock
        acc(1, 0, 2, 16'h0082, "R8"); acc(1, 1, 2, 16'h0083, "R8");
        acc(1, 0, 2, 16'h0083, "R8");
        acc(1, 0, 0, 16'h0099, "R8"); acc(1, 0, 3, 16'h0000, "R8");
        // R9 strap probe
        strap_in = 1;
        acc(1, 0, 5, 16'h00FF, "R9"); acc(0, 1, 5, 0, "R9"); acc(0, 1, 5, 0, "R9");
        strap_in = 0;
        acc(1, 0, 5, 16'h00FF, "R9"); acc(0, 1, 5, 0, "R9");
        strap_in = 1;
        acc(1, 0, 5, 16'h00FF, "R9"); acc(0, 1, 4, 0, "R9"); acc(0, 1, 5, 0, "R9");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int a, k;
            logic [15:0] d;
            bit w, word;
            k = int'($urandom % 16);
            if (k == 0) begin
                unlock("R2");
            end else begin
                a = int'($urandom % 8);
                w = 1'($urandom % 2);
                word = 1'($urandom % 2);
                if (k < 4) a = 1;
                case ($urandom % 6)
                    0: d = 16'h0003;
                    1: d = 16'h0083;
                    2: d = 16'h00FF;
                    3: d = 16'h0085;
                    default: d = 16'($urandom);
                endcase
                if (k == 15) strap_in = ~strap_in;
                acc(w, word, a, d, w ? (m_st == 3 ? "R5" : "R4") : "R10");
            end
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule